// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single bus transfers on a processor bus with a 20-bit address and 16-bit data. The low 16 address bits and the data share one set of pins. The core gives a request: direction, memory or I/O space, address and, for a write, the data. The sequencer then steps through four clock phases, T1, T2, T3 and T4. It adds one wait phase per clock while the external READY line is low at the end of T3 or of a wait phase.

The outputs are the address latch strobe, the space select, the transceiver direction, the read and write strobes, and the transceiver enable. The enable goes active one clock after a strobe starts. The sequencer also drives the shared low pins and the upper pins. The upper pins carry the high address bits in T1 and a status nibble after T1. When a transfer finishes, the block returns the captured read data and raises a completion pulse.

A new request is taken when the sequencer is idle or in T4. This lets transfers follow one another with no idle clock between them.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the sequencer is idle. In the idle state ale=0, rd_n=wr_n=den_n=1, ad_oe=0, dir_tx=1, mem_nio=1, rsp_done=0, req_ready=1, and ad_out and hi_out are zero.
- R2: A request accepted while req_ready=1, with rdy_in high at the end of T3, takes exactly four clocks, T1 to T4. ale is high only in T1, and rsp_done is high for the single T4 clock.
- R3: In T1, ad_out carries addr[15:0] with ad_oe=1, hi_out carries addr[19:16], and ale=1.
- R4: From T2 through T4 and any wait phases, hi_out carries the status nibble {0,0,io,write}: bit 1 is the I/O flag and bit 0 is the write flag.
- R5: In a read, ad_oe=0 from T2 through T4. rd_n is low in T2, T3 and the wait phases and high in T4. dir_tx is 0 from T1 through T4.
- R6: In a write, ad_out carries the write data with ad_oe=1 from T2 through T4. wr_n is low in T2, T3 and the wait phases and high in T4. dir_tx is 1.
- R7: Each clock that ends T3 or a wait phase with rdy_in=0 adds one wait phase. The strobe, the enable and the status stay as they were during the wait phase.
- R8: den_n is low only in T3 and the wait phases, so it always falls one clock after the strobe starts and is never low while both strobes are high.
- R9: Read data is taken from ad_in at the clock edge that ends the last T3 or wait phase. It is shown on rsp_rdata from T4 onward and holds until the next read captures new data. Writes do not change it.
- R10: For the whole T1 to T4 span, mem_nio is 1 for a memory transfer and 0 for an I/O transfer.
- R11: req_ready is high only when the sequencer is idle or in T4. A request in T4 starts its T1 on the next clock. A request raised while req_ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted this clock when high |
| rdy_in | input | 1 | External READY, high ends the access phase |
| ad_in | input | 16 | Value seen on the shared low pins |
| ad_out | output | 16 | Value driven on the shared low pins |
| ad_oe | output | 1 | Drive enable of the shared low pins |
| hi_out | output | 4 | Upper address bits in T1, status nibble after T1 |
| ale | output | 1 | Address latch strobe |
| mem_nio | output | 1 | 1 = memory, 0 = I/O |
| dir_tx | output | 1 | Transceiver direction, 0 = toward core |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| den_n | output | 1 | Active-low transceiver enable |
| rsp_done | output | 1 | One-clock completion pulse in T4 |
| rsp_rdata | output | 16 | Captured read data |

## Verification
Two situations are hard to reach from the ports. The first is a chained transfer, where a new request is accepted in the same clock in which the previous transfer completes. The second is a request that arrives mid-transfer and must be ignored. The bench reaches the first by raising the next request during the T4 of a read and checking that ale appears on the next clock. It reaches the second by raising a request with another address during T2 and checking that T3, T4 and the return to idle show no sign of it. The table vectors use wait counts from zero to three. On the capture edge the bench places the read value on ad_in, and on every other clock it places filler, so data taken one clock early or late shows up as a wrong value.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_TW   = 3'd4,
      PH_T4   = 3'd5
   } bus_phase_t;
endpackage

// File: rtl/mbs_phase_ctrl.sv
module mbs_phase_ctrl
   import mux_bus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              rdy_in,
   output bus_phase_t        phase,
   output logic              cur_write,
   output logic              cur_io,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic              req_ready,
   output logic              cap_en
);
   bus_phase_t nxt;
   logic       accept;
   logic       access_end;

   assign req_ready  = (phase == PH_IDLE) || (phase == PH_T4);
   assign accept     = req_valid && req_ready;
   assign access_end = ((phase == PH_T3) || (phase == PH_TW)) && rdy_in;
   assign cap_en     = access_end && !cur_write;

   always_comb begin
      nxt = phase;
      unique case (phase)
         PH_IDLE: if (accept) nxt = PH_T1;
         PH_T1:   nxt = PH_T2;
         PH_T2:   nxt = PH_T3;
         PH_T3,
         PH_TW:   nxt = rdy_in ? PH_T4 : PH_TW;
         PH_T4:   nxt = accept ? PH_T1 : PH_IDLE;
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cur_write <= 1'b0;
         cur_io    <= 1'b0;
         cur_addr  <= '0;
         cur_wdata <= '0;
      end else begin
         phase <= nxt;
         if (accept) begin
            cur_write <= req_write;
            cur_io    <= req_io;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
         end
      end
   end
endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
   import mux_bus_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 16,
   parameter int DEN_LAG = 1,
   localparam int HI_W   = ADDR_W - DATA_W
) (
   input  bus_phase_t        phase,
   input  logic              cur_write,
   input  logic              cur_io,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [DATA_W-1:0] cur_wdata,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [HI_W-1:0]   hi_out,
   output logic              ale,
   output logic              mem_nio,
   output logic              dir_tx,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              rsp_done
);
   logic            in_t1;
   logic            in_cycle;
   logic            strobe_on;
   logic            data_phase;
   logic [HI_W-1:0] status;

   assign in_t1      = (phase == PH_T1);
   assign in_cycle   = (phase != PH_IDLE);
   assign strobe_on  = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
   assign data_phase = strobe_on || (phase == PH_T4);

   always_comb begin
      status    = '0;
      status[1] = cur_io;
      status[0] = cur_write;
   end

   assign ale      = in_t1;
   assign hi_out   = in_t1 ? cur_addr[ADDR_W-1:DATA_W] : (in_cycle ? status : '0);
   assign ad_oe    = in_t1 || (cur_write && data_phase);
   assign ad_out   = in_t1 ? cur_addr[DATA_W-1:0]
                           : ((cur_write && data_phase) ? cur_wdata : '0);
   assign mem_nio  = in_cycle ? !cur_io : 1'b1;
   assign dir_tx   = in_cycle ? cur_write : 1'b1;
   assign rd_n     = !(strobe_on && !cur_write);
   assign wr_n     = !(strobe_on && cur_write);
   assign rsp_done = (phase == PH_T4);

   generate
      if (DEN_LAG != 0) begin : g_den_late
         assign den_n = !((phase == PH_T3) || (phase == PH_TW));
      end else begin : g_den_with_strobe
         assign den_n = !strobe_on;
      end
   endgenerate
endmodule

// File: rtl/mbs_capture.sv
module mbs_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] rsp_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rsp_rdata <= '0;
      else if (cap_en) rsp_rdata <= ad_in;
   end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mux_bus_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 16,
   parameter int DEN_LAG = 1,
   localparam int HI_W   = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   input  logic              rdy_in,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [HI_W-1:0]   hi_out,
   output logic              ale,
   output logic              mem_nio,
   output logic              dir_tx,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata
);
   generate
      if (HI_W < 2) begin : g_bad_width
         $error("mux_bus_seq: ADDR_W must exceed DATA_W by at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mux_bus_seq: DATA_W must be positive");
      end
   endgenerate

   bus_phase_t        phase;
   logic              cur_write;
   logic              cur_io;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;
   logic              cap_en;

   mbs_phase_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_io    (req_io),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rdy_in    (rdy_in),
      .phase     (phase),
      .cur_write (cur_write),
      .cur_io    (cur_io),
      .cur_addr  (cur_addr),
      .cur_wdata (cur_wdata),
      .req_ready (req_ready),
      .cap_en    (cap_en)
   );

   mbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEN_LAG(DEN_LAG)) u_pins (
      .phase     (phase),
      .cur_write (cur_write),
      .cur_io    (cur_io),
      .cur_addr  (cur_addr),
      .cur_wdata (cur_wdata),
      .ad_out    (ad_out),
      .ad_oe     (ad_oe),
      .hi_out    (hi_out),
      .ale       (ale),
      .mem_nio   (mem_nio),
      .dir_tx    (dir_tx),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .den_n     (den_n),
      .rsp_done  (rsp_done)
   );

   mbs_capture #(.DATA_W(DATA_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .ad_in     (ad_in),
      .rsp_rdata (rsp_rdata)
   );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
   parameter int DEN_LAG = 1
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic rdy_in,
   input logic ad_oe,
   input logic ale,
   input logic rd_n,
   input logic wr_n,
   input logic den_n,
   input logic rsp_done
);
   assert_ale_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_addr_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> ad_oe);

   assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!den_n && !rdy_in) |=> (!den_n && (!rd_n || !wr_n)));

   assert_den_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !den_n |-> (!rd_n || !wr_n));

   assert_den_not_leading_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n) || $fell(wr_n)) |-> (den_n || (DEN_LAG == 0)));

   assert_accept_starts_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> ale);
endmodule

bind mux_bus_seq mbs_checker #(.DEN_LAG(DEN_LAG)) u_mbs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rdy_in    (rdy_in),
   .ad_oe     (ad_oe),
   .ale       (ale),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .den_n     (den_n),
   .rsp_done  (rsp_done)
);

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;
   localparam int P_IDLE = 0, P_T1 = 1, P_T2 = 2, P_T3 = 3, P_TW = 4, P_T4 = 5;
   localparam logic [15:0] FILL = 16'hD00D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic        rdy_in = 1'b1;
   logic [15:0] ad_in = FILL;
   logic [15:0] ad_out;
   logic        ad_oe;
   logic [3:0]  hi_out;
   logic        ale, mem_nio, dir_tx, rd_n, wr_n, den_n, rsp_done;
   logic [15:0] rsp_rdata;

   int errors = 0;
   int checks = 0;
   bit finished = 0;
   logic [15:0] model_rdata = '0;

   always #4 clk = ~clk;

   mux_bus_seq u_mux_bus_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rdy_in(rdy_in), .ad_in(ad_in), .ad_out(ad_out),
      .ad_oe(ad_oe), .hi_out(hi_out), .ale(ale), .mem_nio(mem_nio),
      .dir_tx(dir_tx), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
   );

   // {write, io, addr[19:0], wdata[15:0], waits[2:0], bus read value[15:0]}
   localparam logic [56:0] VEC [6] = '{
      {1'b0, 1'b0, 20'hA1234, 16'h0000, 3'd0, 16'hBEEF},
      {1'b1, 1'b0, 20'h5F00F, 16'h1357, 3'd0, 16'h0000},
      {1'b0, 1'b1, 20'h003F8, 16'h0000, 3'd1, 16'h00C3},
      {1'b1, 1'b1, 20'h00061, 16'hA5A5, 3'd2, 16'h0000},
      {1'b0, 1'b0, 20'hFFFFF, 16'h0000, 3'd3, 16'hFFFF},
      {1'b1, 1'b0, 20'h00000, 16'h8001, 3'd1, 16'h0000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected pin state per phase, computed from the requirements
   task automatic expect_phase(input int ph, input logic w, input logic io,
                               input logic [19:0] a, input logic [15:0] wd,
                               input string tag);
      logic strobe, oe;
      logic [8:0] exp_ctl, act_ctl;
      strobe = (ph == P_T2) || (ph == P_T3) || (ph == P_TW);
      oe = (ph == P_T1) || (w && (strobe || ph == P_T4));
      exp_ctl = {ph == P_T1, !(strobe && !w), !(strobe && w),
                 !(ph == P_T3 || ph == P_TW),
                 (ph == P_IDLE) ? 1'b1 : w, (ph == P_IDLE) ? 1'b1 : !io,
                 oe, ph == P_T4, (ph == P_IDLE) || (ph == P_T4)};
      act_ctl = {ale, rd_n, wr_n, den_n, dir_tx, mem_nio, ad_oe, rsp_done, req_ready};
      chk({tag, " ctl{ale,rd,wr,den,dir,mio,oe,done,rdy}"}, 32'(act_ctl), 32'(exp_ctl));
      if (ph == P_T1) begin
         chk({tag, " R3 ad_out address"}, 32'(ad_out), 32'(a[15:0]));
         chk({tag, " R3 hi_out address"}, 32'(hi_out), 32'(a[19:16]));
      end else if (ph == P_IDLE) begin
         chk({tag, " R1 idle pins"}, 32'({ad_out, hi_out}), 32'd0);
      end else begin
         chk({tag, " R4 status nibble"}, 32'(hi_out), 32'({2'b00, io, w}));
         if (w) chk({tag, " R6 write data"}, 32'(ad_out), 32'(wd));
      end
   endtask

   task automatic drive_req(input logic w, input logic io, input logic [19:0] a,
                            input logic [15:0] wd);
      req_valid = 1'b1; req_write = w; req_io = io; req_addr = a; req_wdata = wd;
   endtask

   // starts at a negedge where req_ready is high; ends at the negedge inside T4
   task automatic run_vec(input logic [56:0] v, input string tag);
      logic w, io;
      logic [19:0] a;
      logic [15:0] wd, bus;
      int waits;
      w = v[56]; io = v[55]; a = v[54:35]; wd = v[34:19]; waits = int'(v[18:16]); bus = v[15:0];
      drive_req(w, io, a, wd);
      @(negedge clk); req_valid = 1'b0;
      expect_phase(P_T1, w, io, a, wd, {tag, " R2 T1"});
      @(negedge clk);
      expect_phase(P_T2, w, io, a, wd, {tag, " R5/R6 T2"});
      @(negedge clk);
      expect_phase(P_T3, w, io, a, wd, {tag, " R8 T3"});
      rdy_in = (waits == 0);
      ad_in  = (waits == 0) ? bus : FILL;
      for (int k = 1; k <= waits; k++) begin
         @(negedge clk);
         expect_phase(P_TW, w, io, a, wd, {tag, " R7 wait"});
         rdy_in = (k == waits);
         ad_in  = (k == waits) ? bus : FILL;
      end
      @(negedge clk);
      rdy_in = 1'b1; ad_in = FILL;
      expect_phase(P_T4, w, io, a, wd, {tag, " R2 T4"});
      if (!w) model_rdata = bus;
      chk({tag, " R9 read data"}, 32'(rsp_rdata), 32'(model_rdata));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk("R1 reset ready", 32'(req_ready), 32'd1);
      expect_phase(P_IDLE, 1'b0, 1'b0, 20'h0, 16'h0, "R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      expect_phase(P_IDLE, 1'b0, 1'b0, 20'h0, 16'h0, "R1 after reset");
      chk("R9 reset rdata", 32'(rsp_rdata), 32'd0);

      // table of vectors, each separated by one idle clock
      for (int i = 0; i < 6; i++) begin
         run_vec(VEC[i], $sformatf("vec%0d R10", i));
         @(negedge clk);
         expect_phase(P_IDLE, 1'b0, 1'b0, 20'h0, 16'h0, $sformatf("vec%0d R2 back to idle", i));
         chk($sformatf("vec%0d R9 hold", i), 32'(rsp_rdata), 32'(model_rdata));
      end

      // R11 back-to-back: next request raised during T4
      run_vec({1'b0, 1'b1, 20'h12345, 16'h0, 3'd0, 16'h4242}, "chainA R11");
      run_vec({1'b1, 1'b0, 20'h6789A, 16'h5AA5, 3'd1, 16'h0}, "chainB R11");
      run_vec({1'b0, 1'b0, 20'hBCDEF, 16'h0, 3'd2, 16'h0F0F}, "chainC R11");
      @(negedge clk);
      expect_phase(P_IDLE, 1'b0, 1'b0, 20'h0, 16'h0, "chain R11 idle");

      // R11 ignored request: raised in T2 with another address, dropped before T4
      drive_req(1'b1, 1'b0, 20'h2468A, 16'h7E7E);
      @(negedge clk); req_valid = 1'b0;
      expect_phase(P_T1, 1'b1, 1'b0, 20'h2468A, 16'h7E7E, "ign R11 T1");
      @(negedge clk);
      drive_req(1'b0, 1'b1, 20'h13579, 16'h0000);
      expect_phase(P_T2, 1'b1, 1'b0, 20'h2468A, 16'h7E7E, "ign R11 T2");
      rdy_in = 1'b1;
      @(negedge clk);
      expect_phase(P_T3, 1'b1, 1'b0, 20'h2468A, 16'h7E7E, "ign R11 T3");
      req_valid = 1'b0;
      @(negedge clk);
      expect_phase(P_T4, 1'b1, 1'b0, 20'h2468A, 16'h7E7E, "ign R11 T4");
      @(negedge clk);
      expect_phase(P_IDLE, 1'b0, 1'b0, 20'h0, 16'h0, "ign R11 idle");
      chk("ign R9 rdata unchanged by write", 32'(rsp_rdata), 32'(model_rdata));

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule